// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an eight-bit storage and shift register. Its parallel port is one bidirectional bus: the same lines carry data into the register during a load and carry the register contents out when the bus is driven. A two-bit select input picks one of four actions, and the register performs it on each rising clock edge. The four actions are keep, shift toward the high bit, shift toward the low bit, and capture the bus.

A serial input sits at each end of the register. A serial output is taken from each end stage. These four pins let several instances be chained into a wider register, and the far ends can be looped back to rotate the whole chain. Two active-low enables gate the bus drivers. A load always turns the drivers off so that the bus can be read. An active-low reset clears the contents at once, without waiting for the clock.

The bidirectional bus is split into three signals: `bus_in` (value seen on the lines), `bus_out` (value offered to the lines) and `bus_drive` (high when the lines are driven). A pad ring or a tri-state wrapper combines them. Control pins are plain levels. The block moves no stream of data, so it has no handshake; a new action is accepted on every clock edge.

Top module: `ushift_bus_reg`

## Requirements
- R1: While `rst_n` is low, all register bits are 0. This takes effect within the same clock period, without a clock edge, and holds whatever the other inputs are.
- R2: With `sel` = 2'b00, a rising edge leaves the contents unchanged.
- R3: With `sel` = 2'b01, a rising edge moves bit i to bit i+1 and puts `ser_lo_in` into bit 0.
- R4: With `sel` = 2'b10, a rising edge moves bit i+1 to bit i and puts `ser_hi_in` into bit 7.
- R5: With `sel` = 2'b11, a rising edge copies `bus_in` into all eight bits. The levels of `oe_a_n` and `oe_b_n` make no difference.
- R6: `bus_drive` is 0 whenever `sel` = 2'b11.
- R7: `bus_drive` is 0 whenever `oe_a_n` or `oe_b_n` is 1.
- R8: When both enables are 0 and `sel` is not 2'b11, `bus_drive` is 1. In every mode `bus_out` carries the register contents, with bit 0 of `bus_out` holding register bit 0.
- R9: `ser_lo_out` always equals register bit 0 and `ser_hi_out` always equals register bit 7. The enables do not affect them.
- R10: Two instances can be chained into 16 bits. For a shift toward the high bit, `ser_hi_out` of the lower instance feeds `ser_lo_in` of the upper one. For a shift toward the low bit, `ser_lo_out` of the upper instance feeds `ser_hi_in` of the lower one. Both directions then shift correctly, and looping the far ends back rotates all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all actions occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Action select: 00 keep, 01 shift up, 10 shift down, 11 load |
| ser_lo_in | input | 1 | Serial data entering bit 0 during a shift up |
| ser_hi_in | input | 1 | Serial data entering bit 7 during a shift down |
| oe_a_n | input | 1 | Active-low bus drive enable, first of two |
| oe_b_n | input | 1 | Active-low bus drive enable, second of two |
| bus_in | input | 8 | Level seen on the shared bus lines |
| bus_out | output | 8 | Register contents offered to the bus lines |
| bus_drive | output | 1 | High when the bus lines are driven |
| ser_lo_out | output | 1 | Register bit 0 |
| ser_hi_out | output | 1 | Register bit 7 |

## Verification
The clocked properties that relate the register's next value to its previous one assume two things: `sel`, the serial inputs and `bus_in` are steady across each rising edge, and any reset pulse covers at least one rising edge. A pulse that starts and ends between two edges would clear the contents without the property seeing `rst_n` low. The stimulus changes inputs only on falling edges. The one mid-period reset in the bench is asserted a few nanoseconds after a rising edge and is released only on a falling edge after a later rising edge. This keeps every pulse within both assumptions while still showing that the clear does not wait for the clock.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic [1:0] sel,
  output usr_mode_e  mode,
  output logic       load_sel
);
  always_comb begin
    mode     = usr_mode_e'(sel);
    load_sel = (mode == MODE_LOAD);
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e mode,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      par_d,
  output logic      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_KEEP: q <= q;
        MODE_UP:   q <= from_below;
        MODE_DOWN: q <= from_above;
        MODE_LOAD: q <= par_d;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/usr_drive_ctl.sv
module usr_drive_ctl (
  input  logic oe_a_n,
  input  logic oe_b_n,
  input  logic load_sel,
  output logic drive_en
);
  always_comb drive_en = ~oe_a_n & ~oe_b_n & ~load_sel;
endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic         ser_lo_in,
  input  logic         ser_hi_in,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic         ser_lo_out,
  output logic         ser_hi_out
);
  localparam int MSB = W - 1;

  usr_mode_e    mode;
  logic         load_sel;
  logic [MSB:0] q;
  logic [W:0]   up_chain;
  logic [W:0]   dn_chain;

  usr_mode_dec dec_i (
    .sel      (sel),
    .mode     (mode),
    .load_sel (load_sel)
  );

  // up_chain[i] feeds bit i on a shift up; dn_chain[i+1] feeds bit i on a shift down
  assign up_chain = {q, ser_lo_in};
  assign dn_chain = {ser_hi_in, q};

  for (genvar i = 0; i < W; i++) begin : g_cell
    usr_cell cell_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .from_below (up_chain[i]),
      .from_above (dn_chain[i+1]),
      .par_d      (bus_in[i]),
      .q          (q[i])
    );
  end

  usr_drive_ctl drv_i (
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .load_sel (load_sel),
    .drive_en (bus_drive)
  );

  assign bus_out    = q;
  assign ser_lo_out = q[0];
  assign ser_hi_out = q[MSB];
endmodule

// File: rtl/usr_chk.sv
module usr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   sel,
  input logic         ser_lo_in,
  input logic         ser_hi_in,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_drive,
  input logic         ser_lo_out,
  input logic         ser_hi_out
);
  assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 2'b00) |-> $stable(bus_out));

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 2'b01) |->
      bus_out == {$past(bus_out[W-2:0]), $past(ser_lo_in)});

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 2'b10) |->
      bus_out == {$past(ser_hi_in), $past(bus_out[W-1:1])});

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel) == 2'b11) |-> bus_out == $past(bus_in));

  assert_load_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !bus_drive);

  assert_enable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !bus_drive);

  assert_enable_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n && sel != 2'b11) |-> bus_drive);

  assert_serial_taps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_lo_out == bus_out[0]) && (ser_hi_out == bus_out[W-1]));
endmodule

bind ushift_bus_reg usr_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .ser_lo_in  (ser_lo_in),
  .ser_hi_in  (ser_hi_in),
  .oe_a_n     (oe_a_n),
  .oe_b_n     (oe_b_n),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .bus_drive  (bus_drive),
  .ser_lo_out (ser_lo_out),
  .ser_hi_out (ser_hi_out)
);

// File: tb/ushift_bus_reg_tb_top.sv
module ushift_bus_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       ser_lo_in = 1'b0;
  logic       ser_hi_in = 1'b0;
  logic       oe_a_n = 1'b0;
  logic       oe_b_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_drive;
  logic       ser_lo_out;
  logic       ser_hi_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ushift_bus_reg dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_lo_in(ser_lo_in),
    .ser_hi_in(ser_hi_in), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
  );

  // two chained instances, far ends looped back for rotation
  logic [1:0]  c_sel = 2'b00;
  logic [15:0] c_din = 16'h0000;
  logic [7:0]  lo_q, hi_q;
  logic        lo_d, lo_s0, lo_s7, hi_d, hi_s0, hi_s7;

  ushift_bus_reg casc_lo (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_lo_in(hi_s7),
    .ser_hi_in(hi_s0), .oe_a_n(1'b0), .oe_b_n(1'b0),
    .bus_in(c_din[7:0]), .bus_out(lo_q), .bus_drive(lo_d),
    .ser_lo_out(lo_s0), .ser_hi_out(lo_s7)
  );
  ushift_bus_reg casc_hi (
    .clk(clk), .rst_n(rst_n), .sel(c_sel), .ser_lo_in(lo_s7),
    .ser_hi_in(lo_s0), .oe_a_n(1'b0), .oe_b_n(1'b0),
    .bus_in(c_din[15:8]), .bus_out(hi_q), .bus_drive(hi_d),
    .ser_lo_out(hi_s0), .ser_hi_out(hi_s7)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       slo;
    logic       shi;
    logic [7:0] din;
    logic       oea;
    logic       oeb;
    logic [7:0] q;
    logic       drv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b0},
    '{2'b00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'hA5, 1'b1},
    '{2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h4B, 1'b1},
    '{2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h96, 1'b0},
    '{2'b10, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'hCB, 1'b0},
    '{2'b10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h65, 1'b1},
    '{2'b11, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0},
    '{2'b00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h3C, 1'b1}
  };

  task automatic check(input logic ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] model;
    repeat (2) @(negedge clk);
    check(bus_out == 8'h00, "R1 reset state", {8'h0, bus_out}, 16'h0);
    check(bus_drive == 1'b1, "R8 drive after reset", {15'h0, bus_drive}, 16'h1);
    rst_n = 1'b1;

    // vector table: apply on falling edge, act on rising edge, sample next falling edge
    for (int i = 0; i < NV; i++) begin
      sel = VECS[i].sel; ser_lo_in = VECS[i].slo; ser_hi_in = VECS[i].shi;
      bus_in = VECS[i].din; oe_a_n = VECS[i].oea; oe_b_n = VECS[i].oeb;
      @(posedge clk);
      @(negedge clk);
      check(bus_out == VECS[i].q, "R2/R3/R4/R5 contents",
            {8'h0, bus_out}, {8'h0, VECS[i].q});
      check(bus_drive == VECS[i].drv, "R6/R7/R8 drive",
            {15'h0, bus_drive}, {15'h0, VECS[i].drv});
      check(ser_lo_out == VECS[i].q[0] && ser_hi_out == VECS[i].q[7],
            "R9 serial taps", {14'h0, ser_hi_out, ser_lo_out},
            {14'h0, VECS[i].q[7], VECS[i].q[0]});
    end

    // R9: taps stay valid with both enables high
    oe_a_n = 1'b1; oe_b_n = 1'b1; sel = 2'b00;
    #1;
    check(ser_lo_out == 1'b0 && ser_hi_out == 1'b0 && bus_drive == 1'b0,
          "R9 taps with enables off", {14'h0, ser_hi_out, ser_lo_out}, 16'h0);

    // R5: load with one enable high
    oe_a_n = 1'b0; oe_b_n = 1'b1; sel = 2'b11; bus_in = 8'h81;
    @(posedge clk); @(negedge clk);
    check(bus_out == 8'h81, "R5 load ignores enables", {8'h0, bus_out}, 16'h0081);

    // R1: reset in the middle of a clock period, overriding a load
    oe_b_n = 1'b0; sel = 2'b11; bus_in = 8'hFF;
    @(posedge clk);
    #5 rst_n = 1'b0;
    #2;
    check(bus_out == 8'h00, "R1 async clear mid-period", {8'h0, bus_out}, 16'h0);
    @(posedge clk); @(negedge clk);
    check(bus_out == 8'h00, "R1 clear overrides load", {8'h0, bus_out}, 16'h0);
    sel = 2'b00; rst_n = 1'b1;

    // R10: chained 16-bit register, both directions with rotation
    c_sel = 2'b11; c_din = 16'h8013;
    @(posedge clk); @(negedge clk);
    model = 16'h8013;
    check({hi_q, lo_q} == model, "R10 chain load", {hi_q, lo_q}, model);
    c_sel = 2'b01;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      model = {model[14:0], model[15]};
      check({hi_q, lo_q} == model, "R10 chain shift up", {hi_q, lo_q}, model);
    end
    c_sel = 2'b10;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      model = {model[0], model[15:1]};
      check({hi_q, lo_q} == model, "R10 chain shift down", {hi_q, lo_q}, model);
    end
    c_sel = 2'b01;
    repeat (16) @(posedge clk);
    @(negedge clk);
    check({hi_q, lo_q} == model, "R10 full 16-bit rotation", {hi_q, lo_q}, model);
    c_sel = 2'b00;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule